// File: doc/BRIEF.md
# Power Serial Link Transceiver

This block moves one 32-bit unsigned average-power word off chip and, over the same framing, brings two 16-bit compensation parameters (A and B) back in. A frame begins each time the power integrator signals that a period has finished. On that strobe the block captures the power word and the period selection. It then produces a serial clock and a one-cell sync marker, shifts the word out MSB first, and shifts 32 received bits in. A single sync pulse frames both directions.

The serial clock rate follows the selected integration period, so that 32 bit cells fill exactly one period. The four selection codes give periods of 64, 128, 256 and 512 system clocks, which means a bit cell of 2, 4, 8 or 16 clocks. Transmit and receive each have their own enable. While receive is disabled, the parameter outputs come from two register inputs instead of the link.

Top module: `pwr_serial_link`

## Requirements
- R1: While reset is asserted and just after it is released, ser_clk, ser_sync and ser_out are low and the captured A and B are zero. With rx_en high, coef_a and coef_b therefore read zero.
- R2: At the clock edge where period_stb is sampled high, power_in is latched and a frame starts. In bit cell k (k = 0..31), ser_out carries latched bit 31-k, so the word goes out MSB first.
- R3: A bit cell lasts 2 << period_sel clocks. ser_clk is low for the first half of the cell and high for the second half. A frame is 32 cells, which is 64 << period_sel clocks (64/128/256/512 for codes 0/1/2/3). After the last cell, ser_clk, ser_sync and ser_out return low and stay low until the next strobe.
- R4: ser_sync is high for the whole of bit cell 0 of a frame and low at all other times.
- R5: ser_out changes only at a cell boundary, which is the falling edge of ser_clk. tx_en is sampled at each cell start. Any cell that starts while tx_en is low drives ser_out low.
- R6: A change on power_in after the strobe has no effect on the frame being sent.
- R7: ser_in is sampled at the clock edge where ser_clk rises. Bit 0 of a frame is the MSB of A, bit 15 is the LSB of A, bit 16 is the MSB of B and bit 31 is the LSB of B. With rx_en high, the new A and B appear on coef_a and coef_b in the cycle after the 32nd sample.
- R8: A and B update together and only at the 32nd sample of a frame. Before that edge, coef_a and coef_b keep their previous values.
- R9: With rx_en low, coef_a equals reg_a and coef_b equals reg_b, and frames do not change the captured values. Raising rx_en again shows the values captured before.
- R10: A strobe that arrives during a frame restarts the frame with the new power word. The interrupted frame updates neither A nor B.
- R11: period_sel is latched at the strobe. A change during a frame does not alter the cell length until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_stb | input | 1 | Integration period complete; starts a frame |
| period_sel | input | 2 | Integration period code (cell = 2 << code clocks) |
| power_in | input | 32 | Average power word from the integrator |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| reg_a | input | 16 | Register value of A, used when receive is disabled |
| reg_b | input | 16 | Register value of B, used when receive is disabled |
| ser_in | input | 1 | Serial parameter input |
| ser_clk | output | 1 | Serial clock |
| ser_sync | output | 1 | Frame marker, high during the first cell |
| ser_out | output | 1 | Serial power output |
| coef_a | output | 16 | Parameter A in use |
| coef_b | output | 16 | Parameter B in use |

## Verification
If the strobe is sampled at edge N, cell k occupies the clock cycles that follow edges N + k·D to N + (k+1)·D − 1, where D = 2 << period_sel. ser_out and ser_sync are valid from edge N + k·D, and ser_clk rises at edge N + k·D + D/2. That same rising edge takes the receive sample, so a new A and B show at the ports after edge N + 31·D + D/2. The bench drives and samples at falling clock edges and counts every clock of each cell. It checks coefficient stability one cycle before the final sample edge and the new values one cycle after it, so every result is read in the cycle it is due.

// File: rtl/pwr_link_pkg.sv
package pwr_link_pkg;
  localparam int COEF_W     = 16;
  localparam int FRAME_BITS = 2 * COEF_W;
  localparam int SEL_W      = 2;
  localparam int CNT_W      = 2 ** SEL_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  // last count value of a bit cell: cell length is 2 << sel clocks
  function automatic logic [CNT_W-1:0] cell_last(input logic [SEL_W-1:0] sel);
    cell_last = CNT_W'((2 << sel) - 1);
  endfunction

  // count value at which the serial clock rises on the next edge
  function automatic logic [CNT_W-1:0] half_last(input logic [SEL_W-1:0] sel);
    half_last = CNT_W'((1 << sel) - 1);
  endfunction
endpackage

// File: rtl/psl_timing.sv
module psl_timing
  import pwr_link_pkg::*;
#(
  parameter int NBITS = FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] period_sel,
  output logic             ser_clk,
  output logic             ser_sync,
  output logic             cell_start,
  output logic             smp_evt,
  output logic             last_smp_evt,
  output logic             frame_end
);
  localparam int NB_W = $clog2(NBITS);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NB_W-1:0]  bit_q;
  logic [SEL_W-1:0] sel_q;
  logic             wrap;
  logic             last_bit;

  always_comb begin
    wrap         = active_q && (cnt_q == cell_last(sel_q));
    last_bit     = (bit_q == NB_W'(NBITS - 1));
    frame_end    = wrap && last_bit;
    smp_evt      = active_q && (cnt_q == half_last(sel_q));
    last_smp_evt = smp_evt && last_bit;
    cell_start   = start || (wrap && !last_bit);
    ser_clk      = active_q && (cnt_q > half_last(sel_q));
    ser_sync     = active_q && (bit_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      sel_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      bit_q    <= '0;
      sel_q    <= period_sel;
    end else if (active_q) begin
      if (wrap) begin
        cnt_q <= '0;
        if (last_bit) active_q <= 1'b0;
        else          bit_q    <= bit_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q <= cell_last(sel_q)));

  p_frame_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !start) |=> (!ser_clk && !ser_sync));

  p_sync_from_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_sync) |-> $past(start));

  p_sel_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !start) |=> $stable(sel_q));
endmodule

// File: rtl/psl_tx.sv
module psl_tx
  import pwr_link_pkg::*;
#(
  parameter int NBITS = FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic             stop,
  input  logic             tx_en,
  input  logic [NBITS-1:0] power_in,
  output logic             ser_out
);
  logic [NBITS-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      ser_out <= 1'b0;
    end else if (load) begin
      sh_q    <= power_in;
      ser_out <= tx_en & power_in[NBITS-1];
    end else if (shift) begin
      sh_q    <= sh_q << 1;
      ser_out <= tx_en & sh_q[NBITS-2];
    end else if (stop) begin
      ser_out <= 1'b0;
    end
  end

  p_serout_cell_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || shift || stop) |=> $stable(ser_out));

  p_tx_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((load || shift) && !tx_en) |=> !ser_out);

  p_word_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || shift) |=> $stable(sh_q));
endmodule

// File: rtl/psl_rx.sv
module psl_rx
  import pwr_link_pkg::*;
#(
  parameter int CW = COEF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          smp,
  input  logic          last_smp,
  input  logic          rx_en,
  input  logic          ser_in,
  input  logic [CW-1:0] reg_a,
  input  logic [CW-1:0] reg_b,
  output logic [CW-1:0] coef_a,
  output logic [CW-1:0] coef_b
);
  localparam int WW = 2 * CW;

  logic [WW-2:0] sh_q;
  logic [WW-1:0] word;
  logic [CW-1:0] a_q, b_q;
  logic          commit;

  always_comb begin
    word   = {sh_q, ser_in};
    commit = last_smp && rx_en && !start;
    coef_a = rx_en ? a_q : reg_a;
    coef_b = rx_en ? b_q : reg_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else begin
      if (start)    sh_q <= '0;
      else if (smp) sh_q <= word[WW-2:0];
      if (commit) begin
        a_q <= word[WW-1:CW];
        b_q <= word[CW-1:0];
      end
    end
  end

  p_coef_atomic_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(a_q) && $stable(b_q)));

  p_abort_no_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/pwr_serial_link.sv
module pwr_serial_link
  import pwr_link_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  period_stb,
  input  logic [SEL_W-1:0]      period_sel,
  input  logic [FRAME_BITS-1:0] power_in,
  input  logic                  tx_en,
  input  logic                  rx_en,
  input  logic [COEF_W-1:0]     reg_a,
  input  logic [COEF_W-1:0]     reg_b,
  input  logic                  ser_in,
  output logic                  ser_clk,
  output logic                  ser_sync,
  output logic                  ser_out,
  output logic [COEF_W-1:0]     coef_a,
  output logic [COEF_W-1:0]     coef_b
);
  logic cell_start, smp_evt, last_smp_evt, frame_end;
  logic tx_shift, tx_stop;

  assign tx_shift = cell_start && !period_stb;
  assign tx_stop  = frame_end && !period_stb;

  psl_timing #(.NBITS(FRAME_BITS)) u_timing (
    .clk(clk), .rst_n(rst_n), .start(period_stb), .period_sel(period_sel),
    .ser_clk(ser_clk), .ser_sync(ser_sync), .cell_start(cell_start),
    .smp_evt(smp_evt), .last_smp_evt(last_smp_evt), .frame_end(frame_end)
  );

  psl_tx #(.NBITS(FRAME_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(period_stb), .shift(tx_shift),
    .stop(tx_stop), .tx_en(tx_en), .power_in(power_in), .ser_out(ser_out)
  );

  psl_rx #(.CW(COEF_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(period_stb), .smp(smp_evt),
    .last_smp(last_smp_evt), .rx_en(rx_en), .ser_in(ser_in),
    .reg_a(reg_a), .reg_b(reg_b), .coef_a(coef_a), .coef_b(coef_b)
  );

  p_out_only_framed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out && !period_stb && frame_end) |=> !ser_out);
endmodule

// File: tb/pwr_serial_link_tb.sv
module pwr_serial_link_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        period_stb = 1'b0;
  logic [1:0]  period_sel = 2'd0;
  logic [31:0] power_in = '0;
  logic        tx_en = 1'b0;
  logic        rx_en = 1'b1;
  logic [15:0] reg_a = 16'h1234;
  logic [15:0] reg_b = 16'hBEEF;
  logic        ser_in = 1'b0;
  logic        ser_clk, ser_sync, ser_out;
  logic [15:0] coef_a, coef_b;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mod_a = '0;
  logic [15:0] mod_b = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_serial_link u_dut (
    .clk(clk), .rst_n(rst_n), .period_stb(period_stb), .period_sel(period_sel),
    .power_in(power_in), .tx_en(tx_en), .rx_en(rx_en), .reg_a(reg_a),
    .reg_b(reg_b), .ser_in(ser_in), .ser_clk(ser_clk), .ser_sync(ser_sync),
    .ser_out(ser_out), .coef_a(coef_a), .coef_b(coef_b)
  );

  // fields: [67:66] sel, [65] tx, [64] rx, [63:32] power word, [31:0] receive word
  localparam logic [67:0] VEC [5] = '{
    {2'd0, 1'b1, 1'b1, 32'hA5A5_0F0F, 32'h1234_ABCD},
    {2'd1, 1'b1, 1'b1, 32'h8000_0001, 32'hFFFF_0000},
    {2'd2, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0001_8000},
    {2'd3, 1'b1, 1'b0, 32'h7E81_C3C3, 32'hDEAD_BEEF},
    {2'd0, 1'b1, 1'b1, 32'h0000_0000, 32'h5555_AAAA}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_coef();
    return rx_en ? {mod_a, mod_b} : {reg_a, reg_b};
  endfunction

  task automatic run_frame(input logic [1:0] sel, input logic [31:0] word,
                           input logic [31:0] rxw, input logic tx, input logic rx,
                           input int nbits, input bit disturb);
    int div;
    int half;
    logic txc;
    div  = 2 << sel;
    half = 1 << sel;
    txc  = tx;
    period_sel = sel; power_in = word; tx_en = tx; rx_en = rx; period_stb = 1'b1;
    @(negedge clk);
    period_stb = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      for (int c = 0; c < div; c++) begin
        if (c == 0) begin
          txc    = tx_en;
          ser_in = rxw[31-k];
        end
        chk(ser_out == (txc & word[31-k]), "R2/R5/R6 ser_out bit", 32'(ser_out), 32'(txc & word[31-k]));
        chk(ser_clk == (c >= half), "R3/R11 ser_clk phase", 32'(ser_clk), 32'(c >= half));
        chk(ser_sync == (k == 0), "R4 ser_sync", 32'(ser_sync), 32'(k == 0));
        if (k == 31 && c == half - 1)
          chk({coef_a, coef_b} == exp_coef(), "R8 coef held before last sample", {coef_a, coef_b}, exp_coef());
        if (k == 31 && c == half) begin
          if (rx) begin
            mod_a = rxw[31:16]; mod_b = rxw[15:0];
            chk({coef_a, coef_b} == exp_coef(), "R7 coef after last sample", {coef_a, coef_b}, exp_coef());
          end else begin
            chk({coef_a, coef_b} == exp_coef(), "R9 coef from registers", {coef_a, coef_b}, exp_coef());
          end
        end
        if (disturb && k == 5 && c == 1) begin
          tx_en = ~tx_en; period_sel = sel + 2'd1; power_in = ~word;
        end
        @(negedge clk);
      end
    end
    if (nbits == 32) begin
      chk({ser_clk, ser_sync, ser_out} == 3'b000, "R3 idle after frame", 32'({ser_clk, ser_sync, ser_out}), 32'd0);
      repeat (3) @(negedge clk);
      chk({ser_clk, ser_sync, ser_out} == 3'b000, "R3 stays idle", 32'({ser_clk, ser_sync, ser_out}), 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk({ser_clk, ser_sync, ser_out} == 3'b000, "R1 outputs in reset", 32'({ser_clk, ser_sync, ser_out}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ser_clk, ser_sync, ser_out} == 3'b000, "R1 outputs after reset", 32'({ser_clk, ser_sync, ser_out}), 32'd0);
    chk({coef_a, coef_b} == 32'd0, "R1 captured coef zero", {coef_a, coef_b}, 32'd0);

    // table of vectors, one full frame each
    foreach (VEC[i])
      run_frame(VEC[i][67:66], VEC[i][63:32], VEC[i][31:0], VEC[i][65], VEC[i][64], 32, 1'b0);

    // R9: re-enabling receive shows the earlier captured values
    rx_en = 1'b0;
    @(negedge clk);
    chk({coef_a, coef_b} == {reg_a, reg_b}, "R9 registers while rx off", {coef_a, coef_b}, {reg_a, reg_b});
    rx_en = 1'b1;
    @(negedge clk);
    chk({coef_a, coef_b} == {mod_a, mod_b}, "R9 captured kept", {coef_a, coef_b}, {mod_a, mod_b});

    // R5/R6/R11: tx_en, power_in and period_sel disturbed mid frame
    run_frame(2'd1, 32'hC0DE_F00D, 32'h0F0F_3C3C, 1'b1, 1'b1, 32, 1'b1);
    run_frame(2'd2, 32'h1357_9BDF, 32'hAAAA_5555, 1'b0, 1'b1, 32, 1'b1);

    // R10: strobe mid frame restarts and discards the partial receive
    run_frame(2'd2, 32'hFACE_B00C, 32'h7777_8888, 1'b1, 1'b1, 12, 1'b0);
    chk({coef_a, coef_b} == {mod_a, mod_b}, "R10 no update from aborted frame", {coef_a, coef_b}, {mod_a, mod_b});
    run_frame(2'd0, 32'h0BAD_CAFE, 32'h2468_1357, 1'b1, 1'b1, 32, 1'b0);
    chk({coef_a, coef_b} == 32'h2468_1357, "R10 restarted frame captured", {coef_a, coef_b}, 32'h2468_1357);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule